// File: doc/BRIEF.md
# Load Result Align and Extend

This stage sits at the end of a load pipeline. It receives a raw 64-bit word read from memory together with the low three bits of the load address, a load-type code, a flag that marks a floating-point destination register, and a valid bit. It produces a register-ready 64-bit result one clock later.

The stage first moves the addressed byte lane down to bit 0. It then widens the selected byte, halfword or word to 64 bits. The widening is a sign extension for signed loads and a zero extension for unsigned loads. A word load whose destination is a floating-point register instead gets its upper half filled with ones, which NaN-boxes a single-precision value. A doubleword load is copied through unchanged.

A small control decoder turns the type code and the floating-point flag into a strobe bundle. The datapath applies that bundle in a single selection path and registers the result.

Top module: `loadResultFormat`

## Requirements
- R1: The address offset k (addrLow, 0..7) shifts the data right by 8k bits, so that data bits [63:8k] land at the bottom of the word and the vacated upper bits read as zero before widening.
- R2: Type code 0 (signed byte) sign-extends bit 7 of the shifted word across bits [63:8].
- R3: Type code 1 (signed halfword) sign-extends bit 15 of the shifted word across bits [63:16].
- R4: Type code 2 (signed word) with fpDest low sign-extends bit 31 of the shifted word across bits [63:32].
- R5: Type code 2 with fpDest high forces bits [63:32] to all ones and keeps the shifted bits [31:0].
- R6: Type code 3 (doubleword) passes the shifted 64 bits through unchanged, whatever the value of fpDest.
- R7: Type codes 4, 5 and 6 (unsigned byte, halfword, word) zero-extend the shifted bits [7:0], [15:0] and [31:0] respectively.
- R8: Type code 7 produces an all-zero result.
- R9: fpDest has no effect on the result for type codes 0, 1, 4, 5 and 6.
- R10: validOut equals validIn of the previous cycle, and resultOut shows the formatted value of the beat presented with validIn in the previous cycle.
- R11: While rstN is low, validOut and resultOut are zero.
- R12: A cycle with validIn low leaves resultOut unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Input beat is valid |
| dataIn | input | 64 | Raw memory word |
| addrLow | input | 3 | Byte offset of the load inside the word |
| loadType | input | 3 | Load type code (0..7, see requirements) |
| fpDest | input | 1 | Destination is a floating-point register |
| validOut | output | 1 | Registered result is valid |
| resultOut | output | 64 | Registered, aligned and widened load result |

## Verification
Lane shifting and widening act on the same beat, so the interesting cases are those where the shift places the sign bit of the narrow value. Examples are a signed byte at offset 7 whose top byte is 0x80, a signed halfword at offset 6, and a word at offset 4 sent once with fpDest low and once with it high. The bench drives these patterns next to cases whose shifted sign bit is zero, such as a word at offset 5. It compares each registered result one edge later against a reference that shifts and then widens on its own terms.

// File: rtl/ldFmtPkg.sv
package ldFmtPkg;

  // Load type codes; bit 2 set means unsigned, bits [1:0] give the size
  typedef enum logic [2:0] {
    LK_SBYTE = 3'd0,
    LK_SHALF = 3'd1,
    LK_SWORD = 3'd2,
    LK_DWORD = 3'd3,
    LK_UBYTE = 3'd4,
    LK_UHALF = 3'd5,
    LK_UWORD = 3'd6,
    LK_RSVD  = 3'd7
  } loadKind_e;

  // Size selector: 0 byte, 1 halfword, 2 word, 3 doubleword
  localparam int SIZE_SEL_W = 2;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic [SIZE_SEL_W-1:0] sizeSel;
    logic                  signExt;
    logic                  nanBox;
    logic                  kill;
  } fmtStrobe_t;

endpackage

// File: rtl/ldFmtCtrl.sv
module ldFmtCtrl
  import ldFmtPkg::*;
(
  input  logic [2:0]  loadType,
  input  logic        fpDest,
  output fmtStrobe_t  stb
);

  always_comb begin
    stb = '0;
    unique case (loadKind_e'(loadType))
      LK_SBYTE: begin stb.sizeSel = 2'd0; stb.signExt = 1'b1; end
      LK_SHALF: begin stb.sizeSel = 2'd1; stb.signExt = 1'b1; end
      LK_SWORD: begin
        stb.sizeSel = 2'd2;
        // floating-point target replaces the sign fill by a ones fill
        stb.signExt = ~fpDest;
        stb.nanBox  = fpDest;
      end
      LK_DWORD: begin stb.sizeSel = 2'd3; end
      LK_UBYTE: begin stb.sizeSel = 2'd0; end
      LK_UHALF: begin stb.sizeSel = 2'd1; end
      LK_UWORD: begin stb.sizeSel = 2'd2; end
      default:  begin stb.kill = 1'b1; end
    endcase
  end

endmodule

// File: rtl/ldFmtPath.sv
module ldFmtPath
  import ldFmtPkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [2:0]        addrLow,
  input  fmtStrobe_t        stb,
  output logic              validOut,
  output logic [DATA_W-1:0] resultOut
);

  localparam int SIZES = SIZE_SEL_W ** 2;

  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] cand [SIZES];
  logic [DATA_W-1:0] nextResult;

  // Lane shift: offset k moves byte k to byte 0
  assign shifted = dataIn >> {addrLow, 3'b000};

  // One widened candidate per access size
  for (genvar s = 0; s < SIZES; s++) begin : gSize
    localparam int LANE_W = 8 << s;
    if (LANE_W >= DATA_W) begin : gFull
      assign cand[s] = shifted;
    end else begin : gPart
      logic fill;
      assign fill    = stb.nanBox | (stb.signExt & shifted[LANE_W-1]);
      assign cand[s] = {{(DATA_W-LANE_W){fill}}, shifted[LANE_W-1:0]};
    end
  end

  assign nextResult = stb.kill ? '0 : cand[stb.sizeSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validOut  <= 1'b0;
      resultOut <= '0;
    end else begin
      validOut <= validIn;
      if (validIn) resultOut <= nextResult;
    end
  end

  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);
  assert_valid_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);
  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> $stable(resultOut));
  assert_kill_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && stb.kill) |=> (resultOut == '0));
  assert_nanbox_ones_R5: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && stb.nanBox && !stb.kill && stb.sizeSel == 2'd2)
      |=> (resultOut[DATA_W-1:32] == '1));
  assert_zext_byte_R7: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !stb.kill && !stb.signExt && !stb.nanBox && stb.sizeSel == 2'd0)
      |=> (resultOut[DATA_W-1:8] == '0));

endmodule

// File: rtl/loadResultFormat.sv
module loadResultFormat
  import ldFmtPkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [2:0]        addrLow,
  input  logic [2:0]        loadType,
  input  logic              fpDest,
  output logic              validOut,
  output logic [DATA_W-1:0] resultOut
);

  fmtStrobe_t stb;

  ldFmtCtrl uCtrl (
    .loadType (loadType),
    .fpDest   (fpDest),
    .stb      (stb)
  );

  ldFmtPath #(.DATA_W(DATA_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .validIn   (validIn),
    .dataIn    (dataIn),
    .addrLow   (addrLow),
    .stb       (stb),
    .validOut  (validOut),
    .resultOut (resultOut)
  );

endmodule

// File: tb/tb_loadResultFormat.sv
`timescale 1ns/1ps
module tb_loadResultFormat;

  logic        clk = 1'b0;
  logic        rstN;
  logic        validIn;
  logic [63:0] dataIn;
  logic [2:0]  addrLow;
  logic [2:0]  loadType;
  logic        fpDest;
  logic        validOut;
  logic [63:0] resultOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  loadResultFormat dut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .dataIn(dataIn),
    .addrLow(addrLow), .loadType(loadType), .fpDest(fpDest),
    .validOut(validOut), .resultOut(resultOut)
  );

  function automatic logic [63:0] refModel(logic [63:0] d, logic [2:0] off,
                                           logic [2:0] t, logic fp);
    logic [63:0] s;
    s = d >> (8 * off);
    case (t)
      3'd0: return {{56{s[7]}},  s[7:0]};
      3'd1: return {{48{s[15]}}, s[15:0]};
      3'd2: return fp ? {32'hFFFF_FFFF, s[31:0]} : {{32{s[31]}}, s[31:0]};
      3'd3: return s;
      3'd4: return {56'd0, s[7:0]};
      3'd5: return {48'd0, s[15:0]};
      3'd6: return {32'd0, s[31:0]};
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // Present one beat, then check the result one edge later
  task automatic beat(string req, logic [63:0] d, logic [2:0] off,
                      logic [2:0] t, logic fp);
    @(negedge clk);
    validIn = 1'b1; dataIn = d; addrLow = off; loadType = t; fpDest = fp;
    @(posedge clk); #1;
    check(req, resultOut, refModel(d, off, t, fp));
    check(req, {63'd0, validOut}, 64'd1);
    @(negedge clk);
    validIn = 1'b0;
  endtask

  task automatic testReset();
    @(posedge clk); #1;
    check("R11", resultOut, 64'd0);
    check("R11", {63'd0, validOut}, 64'd0);
  endtask

  task automatic testOffsets();
    for (int k = 0; k < 8; k++) beat("R1", 64'h8877_6655_4433_2211, 3'(k), 3'd3, 1'b0);
  endtask

  task automatic testSigned();
    beat("R2", 64'h8000_0000_0000_0000, 3'd7, 3'd0, 1'b0);
    beat("R2", 64'h0000_0000_0000_7F00, 3'd1, 3'd0, 1'b0);
    beat("R3", 64'h9ABC_0000_0000_0000, 3'd6, 3'd1, 1'b0);
    beat("R3", 64'h0000_0000_0000_1234, 3'd0, 3'd1, 1'b0);
  endtask

  task automatic testWord();
    beat("R4", 64'hCAFE_F00D_0000_0000, 3'd4, 3'd2, 1'b0);
    beat("R4", 64'hCAFE_F00D_0000_0000, 3'd5, 3'd2, 1'b0);
    beat("R5", 64'hCAFE_F00D_0000_0000, 3'd4, 3'd2, 1'b1);
    beat("R5", 64'h0000_0000_1234_5678, 3'd0, 3'd2, 1'b1);
  endtask

  task automatic testDouble();
    beat("R6", 64'hFEDC_BA98_7654_3210, 3'd0, 3'd3, 1'b1);
    beat("R6", 64'hFEDC_BA98_7654_3210, 3'd3, 3'd3, 1'b1);
  endtask

  task automatic testUnsigned();
    beat("R7", 64'hFF00_0000_0000_0000, 3'd7, 3'd4, 1'b0);
    beat("R7", 64'h0000_0000_F123_0000, 3'd2, 3'd5, 1'b0);
    beat("R7", 64'h8765_4321_0000_0000, 3'd4, 3'd6, 1'b0);
  endtask

  task automatic testReserved();
    beat("R8", 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 3'd7, 1'b0);
    beat("R8", 64'hFFFF_FFFF_FFFF_FFFF, 3'd5, 3'd7, 1'b1);
  endtask

  task automatic testFpIgnored();
    // reference always uses fp=0 here: the flag must not matter
    @(negedge clk);
    for (int t = 0; t < 7; t++) begin
      if (t == 2 || t == 3) continue;
      validIn = 1'b1; dataIn = 64'h8181_8181_8181_8181;
      addrLow = 3'd1; loadType = 3'(t); fpDest = 1'b1;
      @(posedge clk); #1;
      check("R9", resultOut, refModel(64'h8181_8181_8181_8181, 3'd1, 3'(t), 1'b0));
      @(negedge clk);
    end
    validIn = 1'b0;
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    validIn = 1'b1; dataIn = 64'h0000_0000_0000_00F0; addrLow = 3'd0;
    loadType = 3'd0; fpDest = 1'b0;
    @(posedge clk); #1;
    check("R10", resultOut, 64'hFFFF_FFFF_FFFF_FFF0);
    @(negedge clk);
    dataIn = 64'h0000_0000_0000_00F0; loadType = 3'd4;
    check("R10", resultOut, 64'hFFFF_FFFF_FFFF_FFF0);
    @(posedge clk); #1;
    check("R10", resultOut, 64'h0000_0000_0000_00F0);
    check("R10", {63'd0, validOut}, 64'd1);
    @(negedge clk);
    validIn = 1'b0;
    @(posedge clk); #1;
    check("R10", {63'd0, validOut}, 64'd0);
  endtask

  task automatic testHold();
    beat("R12", 64'h1111_2222_3333_4444, 3'd0, 3'd3, 1'b0);
    @(negedge clk);
    validIn = 1'b0; dataIn = 64'hDEAD_BEEF_DEAD_BEEF; loadType = 3'd3;
    @(posedge clk); #1;
    check("R12", resultOut, 64'h1111_2222_3333_4444);
    @(posedge clk); #1;
    check("R12", resultOut, 64'h1111_2222_3333_4444);
  endtask

  initial begin
    rstN = 1'b0; validIn = 1'b1; dataIn = '1; addrLow = '0;
    loadType = 3'd3; fpDest = 1'b0;
    testReset();
    @(negedge clk);
    validIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    testOffsets();
    testSigned();
    testWord();
    testDouble();
    testUnsigned();
    testReserved();
    testFpIgnored();
    testBackToBack();
    testHold();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule